// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block brings a chip's control registers to a known setting straight after reset, without help from software. Once reset is released it fetches bytes from a serial EEPROM one at a time, starting at byte address 0 and counting up. It uses a simple request/acknowledge port, behind which a separate serial-bus master does the real transfers. The byte stream is a chain of typed blocks. A block either sets one 32-bit register or fills a run of consecutive registers. Each completed doubleword goes out at once as a single-cycle write on a CSR bus.

The chain ends with a termination block. That block carries an 8-bit checksum that makes the sum of every stored byte come out to 0xFF, which is the ones' complement rule. A mismatch is flagged unless the skip input is high. The block also flags an EEPROM no-acknowledge, a target address that the register map does not decode, and an image that runs past the byte budget without reaching the termination block. Whether an address is mapped comes from an external lookup input, evaluated on the CSR address output. Error bits stay set until they are cleared by writing ones to them. A done flag rises when loading ends, whether it ended normally or on an error.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: `ee_rd_req` stays high, with `ee_rd_addr` held stable, until `ee_rd_ack` or `ee_rd_nack` is seen high. Byte addresses are requested in ascending order starting at 0. Each acknowledged byte is consumed with `ee_rd_data` valid in the same cycle as the acknowledge.
- R2: A block starts with a type byte whose bits [1:0] give the kind, followed by the target doubleword address as a low byte and then a high byte. Kind 0 then carries four data bytes, least significant first, and produces exactly one write.
- R3: Kind 1 is a sequential block. After the address comes a count byte N, then N doublewords, written to the start address, start+1, and so on. N = 0 writes nothing, and the next byte is parsed as a new type byte.
- R4: Each doubleword is written as soon as its last byte arrives. `csr_wr` is high for one cycle, the cycle after that byte is consumed, with `csr_addr` and `csr_wdata` valid in that cycle.
- R5: If `csr_addr_hit` is low when a doubleword completes, no write is issued and `err_flags[1]` is set. Loading carries on with the next doubleword or block.
- R6: A type byte with bit 1 set (kind 2 or 3) is the termination block. It is followed by one checksum byte, and loading then ends. If the 8-bit sum of all bytes from address 0 through the checksum byte is not 0xFF, `err_flags[3]` is set.
- R7: While `cksum_skip` is high, `err_flags[3]` is never set.
- R8: A no-acknowledge sets `err_flags[0]` and ends loading at once. No write is issued for the block that was in progress.
- R9: When the next byte would lie at address `MAX_BYTES` (default 2048), `err_flags[2]` is set and loading ends. No byte at or beyond that address is requested, and a partly read block is dropped.
- R10: `load_done` rises when loading ends by any route and stays high until reset. While it is high, `ee_rd_req` stays low.
- R11: Each `err_flags` bit stays set until a cycle in which the matching `err_clr` bit is 1. Bits of `err_clr` that are 0 leave their flag unchanged, and a new error event takes precedence over a clear in the same cycle.
- R12: During reset, `load_done`, `err_flags`, `csr_wr` and `ee_rd_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ee_rd_req | output | 1 | Byte read request to the serial-bus master |
| ee_rd_addr | output | $clog2(MAX_BYTES) | EEPROM byte address being requested |
| ee_rd_ack | input | 1 | Byte returned; data valid this cycle |
| ee_rd_nack | input | 1 | EEPROM failed to acknowledge |
| ee_rd_data | input | 8 | Returned byte |
| csr_wr | output | 1 | Register write strobe |
| csr_addr | output | CSR_AW | Target doubleword address, also drives the map lookup |
| csr_wdata | output | 32 | Register write data |
| csr_addr_hit | input | 1 | Lookup result: `csr_addr` is a mapped register |
| cksum_skip | input | 1 | Suppresses the checksum comparison |
| err_clr | input | 4 | Write-one-to-clear strobes for `err_flags` |
| load_done | output | 1 | Loading has ended |
| err_flags | output | 4 | [0] no-acknowledge, [1] unmapped address, [2] missing termination, [3] checksum |

## Verification
The hardest case to reach is the byte-budget exit. It needs an image that fills all 2048 bytes with well-formed blocks and no termination block, and leaves a partial block straddling the last address, so that loading stops mid-block without issuing a write. The bench packs the image with single-register blocks until fewer than seven bytes remain and lets the zero fill form the truncated tail. Other runs use randomly typed images, random acknowledge latency, unmapped addresses and corrupted checksums, with a no-acknowledge placed inside a block's address bytes.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
   // parser states
   typedef enum logic [2:0] {
      PS_TYPE,
      PS_ADRL,
      PS_ADRH,
      PS_NUM,
      PS_DATA,
      PS_CKSUM,
      PS_STOP
   } pstate_e;

   localparam int unsigned NERR       = 4;
   localparam int unsigned ERR_NACK   = 0;
   localparam int unsigned ERR_UNMAP  = 1;
   localparam int unsigned ERR_NOEND  = 2;
   localparam int unsigned ERR_CKSUM  = 3;
   localparam int unsigned DW_BYTES   = 4;
   localparam int unsigned TADDR_W    = 16;
endpackage

// File: rtl/cfgld_fetch.sv
module cfgld_fetch #(
   parameter int unsigned MAX_BYTES = 2048,
   localparam int unsigned BA_W     = $clog2(MAX_BYTES),
   localparam int unsigned CNT_W    = BA_W + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pull,
   output logic            rd_req,
   output logic [BA_W-1:0] rd_addr,
   input  logic            rd_ack,
   input  logic            rd_nack,
   output logic            byte_vld,
   output logic            nack_evt,
   output logic            limit_evt
);
   logic             req_q;
   logic [CNT_W-1:0] pos_q;
   logic             at_end;

   assign at_end    = (pos_q == CNT_W'(MAX_BYTES));
   assign rd_req    = req_q;
   assign rd_addr   = pos_q[BA_W-1:0];
   assign nack_evt  = req_q & rd_nack;
   assign byte_vld  = req_q & rd_ack & ~rd_nack;
   assign limit_evt = pull & ~req_q & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         pos_q <= '0;
      end else if (req_q) begin
         if (rd_ack || rd_nack) req_q <= 1'b0;
         if (byte_vld)          pos_q <= pos_q + 1'b1;
      end else if (pull && !at_end) begin
         req_q <= 1'b1;
      end
   end
endmodule

// File: rtl/cfgld_dword_asm.sv
module cfgld_dword_asm #(
   parameter int unsigned NB = 4,
   localparam int unsigned IW = $clog2(NB)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld,
   input  logic [IW-1:0]   idx,
   input  logic [7:0]      din,
   output logic [NB*8-1:0] nxt
);
   for (genvar g = 0; g < NB; g++) begin : g_lane
      logic [7:0] lane_q;
      logic       hit;
      assign hit = ld && (idx == IW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   lane_q <= '0;
         else if (hit) lane_q <= din;
      end
      assign nxt[g*8 +: 8] = hit ? din : lane_q;
   end
endmodule

// File: rtl/cfgld_sum.sv
module cfgld_sum #(
   parameter bit CKSUM_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       add,
   input  logic [7:0] din,
   output logic       match
);
   if (CKSUM_EN) begin : g_sum
      logic [7:0] sum_q;
      logic [7:0] total;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   sum_q <= '0;
         else if (add) sum_q <= sum_q + din;
      end
      assign total = sum_q + din;
      assign match = (total == 8'hFF);
   end else begin : g_nosum
      assign match = 1'b1;
   end
endmodule

// File: rtl/cfgld_flags.sv
module cfgld_flags #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);
   for (genvar g = 0; g < N; g++) begin : g_bit
      logic f_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      f_q <= 1'b0;
         else if (set[g]) f_q <= 1'b1;
         else if (clr[g]) f_q <= 1'b0;
      end
      assign flags[g] = f_q;
   end
endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader
   import cfgld_pkg::*;
#(
   parameter int unsigned MAX_BYTES = 2048,
   parameter int unsigned CSR_AW    = 16,
   parameter bit          CKSUM_EN  = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   output logic                         ee_rd_req,
   output logic [$clog2(MAX_BYTES)-1:0] ee_rd_addr,
   input  logic                         ee_rd_ack,
   input  logic                         ee_rd_nack,
   input  logic [7:0]                   ee_rd_data,
   output logic                         csr_wr,
   output logic [CSR_AW-1:0]            csr_addr,
   output logic [31:0]                  csr_wdata,
   input  logic                         csr_addr_hit,
   input  logic                         cksum_skip,
   input  logic [NERR-1:0]              err_clr,
   output logic                         load_done,
   output logic [NERR-1:0]              err_flags
);
   localparam int unsigned LIW = $clog2(DW_BYTES);

   if (MAX_BYTES < 2) begin : g_bad_max
      $error("MAX_BYTES must be at least 2");
   end
   if (CSR_AW < 1 || CSR_AW > TADDR_W) begin : g_bad_aw
      $error("CSR_AW must lie in 1..16");
   end

   pstate_e            st_q;
   logic [TADDR_W-1:0] tadr_q;
   logic [7:0]         left_q;
   logic [LIW-1:0]     lane_q;
   logic               seq_q, adv_q, wr_q, done_q;
   logic [31:0]        wdata_q;

   logic               pull, bv, nack_evt, limit_evt, cks_ok;
   logic               in_data, last_lane, cks_byte;
   logic [31:0]        dw_nxt;
   logic [NERR-1:0]    err_set;

   assign pull      = (st_q != PS_STOP) && !adv_q && !done_q;
   assign in_data   = (st_q == PS_DATA) && bv;
   assign last_lane = (lane_q == LIW'(DW_BYTES - 1));
   assign cks_byte  = (st_q == PS_CKSUM) && bv;

   cfgld_fetch #(.MAX_BYTES(MAX_BYTES)) u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .pull     (pull),
      .rd_req   (ee_rd_req),
      .rd_addr  (ee_rd_addr),
      .rd_ack   (ee_rd_ack),
      .rd_nack  (ee_rd_nack),
      .byte_vld (bv),
      .nack_evt (nack_evt),
      .limit_evt(limit_evt)
   );

   cfgld_dword_asm #(.NB(DW_BYTES)) u_asm (
      .clk  (clk),
      .rst_n(rst_n),
      .ld   (in_data),
      .idx  (lane_q),
      .din  (ee_rd_data),
      .nxt  (dw_nxt)
   );

   cfgld_sum #(.CKSUM_EN(CKSUM_EN)) u_sum (
      .clk  (clk),
      .rst_n(rst_n),
      .add  (bv && (st_q != PS_CKSUM)),
      .din  (ee_rd_data),
      .match(cks_ok)
   );

   always_comb begin
      err_set            = '0;
      err_set[ERR_NACK]  = nack_evt;
      err_set[ERR_UNMAP] = in_data && last_lane && !csr_addr_hit;
      err_set[ERR_NOEND] = limit_evt;
      err_set[ERR_CKSUM] = cks_byte && !cksum_skip && !cks_ok;
   end

   cfgld_flags #(.N(NERR)) u_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (err_set),
      .clr  (err_clr),
      .flags(err_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= PS_TYPE;
         tadr_q  <= '0;
         left_q  <= '0;
         lane_q  <= '0;
         seq_q   <= 1'b0;
         adv_q   <= 1'b0;
         wr_q    <= 1'b0;
         wdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         wr_q  <= 1'b0;
         adv_q <= 1'b0;
         if (adv_q) tadr_q <= tadr_q + 1'b1;
         if (cks_byte || nack_evt || limit_evt) done_q <= 1'b1;
         if (nack_evt || limit_evt) begin
            st_q <= PS_STOP;
         end else if (bv) begin
            unique case (st_q)
               PS_TYPE: begin
                  if (ee_rd_data[1]) st_q <= PS_CKSUM;
                  else begin
                     seq_q <= ee_rd_data[0];
                     st_q  <= PS_ADRL;
                  end
               end
               PS_ADRL: begin
                  tadr_q[7:0] <= ee_rd_data;
                  st_q        <= PS_ADRH;
               end
               PS_ADRH: begin
                  tadr_q[15:8] <= ee_rd_data;
                  lane_q       <= '0;
                  left_q       <= 8'd1;
                  st_q         <= seq_q ? PS_NUM : PS_DATA;
               end
               PS_NUM: begin
                  left_q <= ee_rd_data;
                  st_q   <= (ee_rd_data == 8'd0) ? PS_TYPE : PS_DATA;
               end
               PS_DATA: begin
                  lane_q <= lane_q + 1'b1;
                  if (last_lane) begin
                     wdata_q <= dw_nxt;
                     wr_q    <= csr_addr_hit;
                     adv_q   <= 1'b1;
                     left_q  <= left_q - 1'b1;
                     if (left_q == 8'd1) st_q <= PS_TYPE;
                  end
               end
               PS_CKSUM: st_q <= PS_STOP;
               default:  st_q <= PS_STOP;
            endcase
         end
      end
   end

   assign csr_wr    = wr_q;
   assign csr_addr  = tadr_q[CSR_AW-1:0];
   assign csr_wdata = wdata_q;
   assign load_done = done_q;
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
   parameter int unsigned BA_W = 11
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rd_req,
   input logic            rd_ack,
   input logic            rd_nack,
   input logic [BA_W-1:0] rd_addr,
   input logic            csr_wr,
   input logic            csr_addr_hit,
   input logic            load_done,
   input logic [3:0]      err_flags
);
   // R1
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack && !rd_nack) |=> rd_req);
   // R1
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack && !rd_nack) |=> $stable(rd_addr));
   // R4
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csr_wr |=> !csr_wr);
   // R5
   wr_mapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csr_wr |-> csr_addr_hit);
   // R6
   cksum_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flags[3]) |-> $rose(load_done));
   // R10
   idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |-> !rd_req);
   // R10
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(load_done));
endmodule

bind cfg_eeprom_loader cfgld_chk #(.BA_W($clog2(MAX_BYTES))) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_req      (ee_rd_req),
   .rd_ack      (ee_rd_ack),
   .rd_nack     (ee_rd_nack),
   .rd_addr     (ee_rd_addr),
   .csr_wr      (csr_wr),
   .csr_addr_hit(csr_addr_hit),
   .load_done   (load_done),
   .err_flags   (err_flags)
);

// File: tb/cfg_eeprom_loader_tb.sv
module cfg_eeprom_loader_tb;
   localparam int MAXB = 2048;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_req, rd_ack, rd_nack;
   logic [10:0] rd_addr;
   logic [7:0]  rd_data;
   logic        csr_wr, hit, skip, done;
   logic [15:0] csr_addr;
   logic [31:0] csr_wdata;
   logic [3:0]  clr, flags;

   int          n_chk = 0, n_fail = 0;
   logic [7:0]  mem [MAXB];
   int          wp;
   logic [7:0]  sum;
   logic [15:0] ex_a [1024];
   logic [31:0] ex_d [1024];
   int          ex_n, obs_n, exp_rd, nack_at, wait_cnt;
   logic [3:0]  exp_err;

   always #10 clk = ~clk;

   function automatic logic map_ok(input logic [15:0] a);
      return a[15:12] != 4'hF;
   endfunction

   assign hit = map_ok(csr_addr);

   cfg_eeprom_loader u_dut (
      .clk(clk), .rst_n(rst_n), .ee_rd_req(rd_req), .ee_rd_addr(rd_addr),
      .ee_rd_ack(rd_ack), .ee_rd_nack(rd_nack), .ee_rd_data(rd_data),
      .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
      .csr_addr_hit(hit), .cksum_skip(skip), .err_clr(clr),
      .load_done(done), .err_flags(flags)
   );

   task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // EEPROM responder with random latency
   initial begin
      rd_ack = 1'b0; rd_nack = 1'b0; rd_data = '0; wait_cnt = 0;
      forever begin
         @(negedge clk);
         rd_ack = 1'b0; rd_nack = 1'b0;
         if (rd_req) begin
            if (wait_cnt > 0) wait_cnt--;
            else begin
               // R1 ascending order from address 0
               chk(int'(rd_addr) == exp_rd, "R1 byte order", 32'(rd_addr), 32'(exp_rd));
               if (int'(rd_addr) == nack_at) rd_nack = 1'b1;
               else begin
                  rd_ack  = 1'b1;
                  rd_data = mem[rd_addr];
                  exp_rd++;
               end
               wait_cnt = $urandom % 3;
            end
         end
      end
   end

   // CSR write monitor: R2 R3 R4
   initial begin
      forever begin
         @(negedge clk);
         if (csr_wr) begin
            if (obs_n < ex_n) begin
               chk(csr_addr == ex_a[obs_n], "R4 write address", 32'(csr_addr), 32'(ex_a[obs_n]));
               chk(csr_wdata == ex_d[obs_n], "R2 write data", csr_wdata, ex_d[obs_n]);
            end else chk(1'b0, "R4 unexpected write", 32'(csr_addr), 32'(ex_n));
            obs_n++;
         end
      end
   end

   task automatic img_new();
      for (int i = 0; i < MAXB; i++) mem[i] = 8'h00;
      wp = 0; sum = 8'h00; ex_n = 0; exp_err = 4'b0000; nack_at = -1;
   endtask

   task automatic put_b(input logic [7:0] b);
      mem[wp] = b; sum = sum + b; wp++;
   endtask

   task automatic put_dw(input logic [15:0] a, input logic [31:0] d);
      for (int i = 0; i < 4; i++) put_b(d[i*8 +: 8]);
      if (map_ok(a)) begin ex_a[ex_n] = a; ex_d[ex_n] = d; ex_n++; end
      else exp_err[1] = 1'b1;
   endtask

   task automatic blk_single(input logic [15:0] a, input logic [31:0] d);
      put_b(8'h00); put_b(a[7:0]); put_b(a[15:8]); put_dw(a, d);
   endtask

   task automatic blk_seq(input logic [15:0] a, input int n);
      put_b(8'h01); put_b(a[7:0]); put_b(a[15:8]); put_b(8'(n));
      for (int i = 0; i < n; i++) put_dw(a + 16'(i), $urandom);
   endtask

   task automatic blk_done(input logic [7:0] ty, input logic bad);
      logic [7:0] c;
      put_b(ty);
      c = ~sum;
      if (bad) c = c ^ 8'h01;
      mem[wp] = c; wp++;
      if (bad && !skip) exp_err[3] = 1'b1;
   endtask

   task automatic run(input string name);
      int t;
      obs_n = 0; exp_rd = 0; clr = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(done == 1'b0 && flags == 4'b0 && csr_wr == 1'b0 && rd_req == 1'b0,
          "R12 reset state", {27'd0, done, flags}, 32'd0);
      rst_n = 1'b1;
      t = 0;
      while (!done && t < 30000) begin @(negedge clk); t++; end
      chk(done, "R10 load_done", 32'(done), 32'd1);
      repeat (8) @(negedge clk);
      chk(rd_req == 1'b0, "R10 idle after done", 32'(rd_req), 32'd0);
      chk(done == 1'b1, "R10 done sticky", 32'(done), 32'd1);
      chk(obs_n == ex_n, "R4 write count", 32'(obs_n), 32'(ex_n));
      chk(flags == exp_err, "R5 R6 R7 R8 R9 error flags", 32'(flags), 32'(exp_err));
      $display("scenario %s: writes=%0d flags=%b", name, obs_n, flags);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      skip = 1'b0; clr = '0;

      // R2 R3 R6: directed good image, both termination kinds
      img_new(); blk_single(16'h0010, 32'hDEADBEEF); blk_seq(16'h0100, 3);
      blk_done(8'h02, 1'b0); run("basic");
      // R3 count zero then a single
      img_new(); blk_seq(16'h0200, 0); blk_single(16'h0300, 32'h01234567);
      blk_done(8'h03, 1'b0); run("numdw0");
      // R5 unmapped inside a run, loading continues
      img_new(); blk_seq(16'hEFFE, 4); blk_single(16'h0040, 32'hA5A5_5A5A);
      blk_done(8'h02, 1'b0); run("unmapped");
      // R6 bad checksum plus unmapped, then R11 clears
      img_new(); blk_single(16'hF123, 32'h1); blk_single(16'h0001, 32'h2);
      blk_done(8'h02, 1'b1); run("badsum");
      clr = 4'b0010; @(negedge clk); clr = 4'b0000;
      chk(flags == 4'b1000, "R11 clear one bit", 32'(flags), 32'h8);
      clr = 4'b0000; @(negedge clk);
      chk(flags == 4'b1000, "R11 zero clear keeps", 32'(flags), 32'h8);
      clr = 4'b1000; @(negedge clk); clr = 4'b0000;
      chk(flags == 4'b0000, "R11 clear last bit", 32'(flags), 32'h0);
      chk(done == 1'b1, "R10 done unaffected by clear", 32'(done), 32'd1);
      // R7 skip suppresses checksum error
      skip = 1'b1;
      img_new(); blk_single(16'h0002, 32'h3); blk_done(8'h02, 1'b1); run("skip");
      skip = 1'b0;
      // R8 nack inside second block's address bytes
      img_new(); blk_single(16'h0004, 32'h44); blk_single(16'h0005, 32'h55);
      blk_seq(16'h0006, 2); blk_done(8'h02, 1'b0);
      nack_at = 8; ex_n = 1; exp_err = 4'b0001; run("nack");
      // R9 image fills the budget without termination
      img_new();
      while (wp + 7 <= MAXB) blk_single(16'(wp), $urandom);
      exp_err = 4'b0100; run("limit");
      // random images
      for (int k = 0; k < 8; k++) begin
         int nb;
         img_new();
         skip = ($urandom % 4) == 0;
         nb = 1 + ($urandom % 6);
         for (int b = 0; b < nb; b++) begin
            logic [15:0] a;
            a = 16'($urandom);
            if (($urandom % 8) != 0) a[15:12] = 4'h1;
            else a[15:12] = 4'hF;
            if ($urandom % 2) blk_single(a, $urandom);
            else blk_seq(a, $urandom % 6);
         end
         blk_done(($urandom % 2) ? 8'h02 : 8'h03, ($urandom % 4) == 0);
         run("random");
      end

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish actual=hung expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule